// File: doc/BRIEF.md
# I2C Slave Register Bank

This block is a slave on a two-wire I2C bus. Through it a host microcontroller reads and writes a bank of byte-wide registers that configure and observe the rest of the chip. It oversamples SCL and SDA on the system clock. It finds start and stop conditions and matches its fixed 7-bit device address. It acknowledges the address and every byte it receives, and it pulls SDA low only as an open-drain driver.

In a write transaction, the first data byte sets an internal register pointer. Each later byte goes to the register at that pointer, and the pointer then advances. To read, the host first sets the pointer with a short write that ends in a stop. It then opens a read transaction and clocks out the register at the pointer and the registers after it. The lowest twelve sub-addresses hold status, taken live from input ports, and cannot be written. The upper sub-addresses are writable control bytes, and the block presents them on a flat output bus. One status sub-address is banked. A bit in a control register chooses whether that sub-address returns the flag byte, with its identity bit forced high, or the low byte of a constellation monitor.

Top module: `i2c_regbank_slave`

## Requirements
- R1: The block acknowledges (drives SDA low in the ninth clock) only an address byte whose upper seven bits are 1101111, that is 0xDE for write and 0xDF for read. Any other address is not acknowledged and SDA stays released.
- R2: In a write, the first byte after the address loads the pointer. Each following byte is stored at the pointer, which then advances by one. Every received byte is acknowledged.
- R3: Writes aimed at sub-addresses 0x00 to 0x0B change nothing, but the pointer still advances past them. A run that starts at 0x0A therefore lands its third byte in 0x0C.
- R4: Sub-address 0x21 is the last register. Bytes sent after it are acknowledged and discarded, and no register wraps around. A read past 0x21 returns 0x00.
- R5: A read returns the register at the pointer left by earlier transactions, including a pointer-only write that ended in a stop. Each further byte comes from the next sub-address.
- R6: Every sub-address can be read. 0x00 to 0x0B return the status input byte at that index (bits 8*n+7 down to 8*n), and 0x0C to 0x21 return the last value written.
- R7: Sub-address 0x09 is banked by bit 0 of register 0x0E. When that bit is 0, a read of 0x09 returns the flag byte, which is status input byte 9. When it is 1, a read of 0x09 returns the constellation-monitor input.
- R8: In the flag byte, bit 0 is the identity bit and always reads 1, whatever the status input holds.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing until the next start condition.
- R10: A stop or a repeated start in the middle of a byte abandons that byte. No register is written, and SDA is released.
- R11: After reset, SDA is released and every writable register holds 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SCL and SDA are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 leaves it to the pull-up |
| status_i | input | 96 | Twelve status bytes for sub-addresses 0x00 to 0x0B, byte n at bits 8n+7:8n |
| cmon_i | input | 8 | Constellation-monitor low byte, the alternate content of 0x09 |
| ctrl_o | output | 176 | Writable registers 0x0C to 0x21, register a at bits 8(a-12)+7:8(a-12) |

## Verification
The bench builds the block with its default parameters: 34 registers, the first 12 read-only, the banked address at 0x09, its select in bit 0 of 0x0E, and two synchronizer stages. With these values the bench can reach both edges of the read-only region in a single burst, and it can run write and read bursts across the last register into the parked pointer. The bus runs at one SCL quarter-period per eight system clocks. This leaves room for the synchronizer and edge-detect latency ahead of each acknowledge and data bit. The bench also cuts bytes short with a stop and with a repeated start.

// File: rtl/i2c_regbank_pkg.sv
package i2c_regbank_pkg;
  // Protocol engine states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } slv_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizes SCL/SDA and derives edge and bus-condition events.
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;
  logic scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_byte_engine.sv
// Bit/byte protocol engine: address match, ACK, pointer, read/write strobes.
module i2c_byte_engine
  import i2c_regbank_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6F,
  parameter int NUM_REGS = 34,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] ptr,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data
);
  localparam logic [AW-1:0] PARK  = AW'(NUM_REGS);
  localparam logic [7:0]    LIMIT = 8'(NUM_REGS);

  slv_state_t    state_q, state_n;
  logic [3:0]    bits_q, bits_n;
  logic [7:0]    shift_q, shift_n;
  logic [AW-1:0] ptr_q, ptr_n;
  logic          first_q, first_n, rw_q, rw_n, nack_q, nack_n, oe_q, oe_n;
  logic          wr_en_n;

  always_comb begin
    state_n = state_q;
    bits_n  = bits_q;
    shift_n = shift_q;
    ptr_n   = ptr_q;
    first_n = first_q;
    rw_n    = rw_q;
    nack_n  = nack_q;
    oe_n    = oe_q;
    wr_en_n = 1'b0;
    if (stop_ev) begin
      state_n = ST_IDLE;
      oe_n    = 1'b0;
    end else if (start_ev) begin
      state_n = ST_ADDR;
      bits_n  = '0;
      oe_n    = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_ADDR: begin
          if (scl_rise && bits_q != 4'd8) begin
            shift_n = {shift_q[6:0], sda_s};
            bits_n  = bits_q + 4'd1;
          end
          if (scl_fall && bits_q == 4'd8) begin
            if (shift_q[7:1] == DEV_ADDR) begin
              rw_n    = shift_q[0];
              oe_n    = 1'b1;
              state_n = ST_ADDR_ACK;
            end else begin
              state_n = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bits_n = '0;
            if (rw_q) begin
              shift_n = rd_data;
              oe_n    = ~rd_data[7];
              state_n = ST_TX;
            end else begin
              oe_n    = 1'b0;
              first_n = 1'b1;
              state_n = ST_RX;
            end
          end
        end
        ST_RX: begin
          if (scl_rise && bits_q != 4'd8) begin
            shift_n = {shift_q[6:0], sda_s};
            bits_n  = bits_q + 4'd1;
          end
          if (scl_fall && bits_q == 4'd8) begin
            oe_n    = 1'b1;
            state_n = ST_RX_ACK;
            if (first_q) begin
              first_n = 1'b0;
              ptr_n   = (shift_q < LIMIT) ? shift_q[AW-1:0] : PARK;
            end else if (ptr_q != PARK) begin
              wr_en_n = 1'b1;
              ptr_n   = ptr_q + 1'b1;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            oe_n    = 1'b0;
            bits_n  = '0;
            state_n = ST_RX;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            bits_n = bits_q + 4'd1;
            if (bits_q == 4'd7) begin
              oe_n    = 1'b0;
              state_n = ST_TX_ACK;
              if (ptr_q != PARK) ptr_n = ptr_q + 1'b1;
            end else begin
              shift_n = {shift_q[6:0], 1'b0};
              oe_n    = ~shift_q[6];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) nack_n = sda_s;
          if (scl_fall) begin
            if (nack_q) begin
              state_n = ST_IDLE;
            end else begin
              shift_n = rd_data;
              oe_n    = ~rd_data[7];
              bits_n  = '0;
              state_n = ST_TX;
            end
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bits_q  <= '0;
      shift_q <= '0;
      ptr_q   <= '0;
      first_q <= 1'b0;
      rw_q    <= 1'b0;
      nack_q  <= 1'b0;
      oe_q    <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      state_q <= state_n;
      bits_q  <= bits_n;
      shift_q <= shift_n;
      ptr_q   <= ptr_n;
      first_q <= first_n;
      rw_q    <= rw_n;
      nack_q  <= nack_n;
      oe_q    <= oe_n;
      wr_en   <= wr_en_n;
      if (wr_en_n) begin
        wr_addr <= ptr_q;
        wr_data <= shift_q;
      end
    end
  end

  assign ptr    = ptr_q;
  assign sda_oe = oe_q;
endmodule

// File: rtl/i2c_reg_bank.sv
// Writable control bytes plus read mux over status, banked address and controls.
module i2c_reg_bank #(
  parameter int NUM_REGS  = 34,
  parameter int RO_COUNT  = 12,
  parameter int BANK_ADDR = 9,
  parameter int SEL_ADDR  = 14,
  parameter int SEL_BIT   = 0,
  parameter int ID_BIT    = 0,
  parameter int AW        = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [AW-1:0]                  wr_addr,
  input  logic [7:0]                     wr_data,
  input  logic [AW-1:0]                  rd_addr,
  input  logic [RO_COUNT*8-1:0]          status_i,
  input  logic [7:0]                     cmon_i,
  output logic [7:0]                     rd_data,
  output logic [(NUM_REGS-RO_COUNT)*8-1:0] ctrl_o
);
  localparam int RW_COUNT = NUM_REGS - RO_COUNT;
  localparam int SEL_POS  = (SEL_ADDR - RO_COUNT) * 8 + SEL_BIT;

  for (genvar g = 0; g < RW_COUNT; g++) begin : g_ctrl
    logic       hit;
    logic [7:0] byte_q;
    assign hit = wr_en && (wr_addr == AW'(RO_COUNT + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   byte_q <= '0;
      else if (hit) byte_q <= wr_data;
    end
    assign ctrl_o[g*8 +: 8] = byte_q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < RO_COUNT; i++) begin
      if (rd_addr == AW'(i)) begin
        if (i == BANK_ADDR)
          rd_data = ctrl_o[SEL_POS] ? cmon_i
                                    : (status_i[i*8 +: 8] | (8'd1 << ID_BIT));
        else
          rd_data = status_i[i*8 +: 8];
      end
    end
    for (int i = 0; i < RW_COUNT; i++) begin
      if (rd_addr == AW'(RO_COUNT + i)) rd_data = ctrl_o[i*8 +: 8];
    end
  end
endmodule

// File: rtl/i2c_regbank_slave.sv
// Top: I2C slave giving bus access to a status/control register bank.
module i2c_regbank_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h6F,
  parameter int NUM_REGS    = 34,
  parameter int RO_COUNT    = 12,
  parameter int BANK_ADDR   = 9,
  parameter int SEL_ADDR    = 14,
  parameter int SEL_BIT     = 0,
  parameter int ID_BIT      = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             scl_i,
  input  logic                             sda_i,
  output logic                             sda_oe_o,
  input  logic [RO_COUNT*8-1:0]            status_i,
  input  logic [7:0]                       cmon_i,
  output logic [(NUM_REGS-RO_COUNT)*8-1:0] ctrl_o
);
  localparam int AW = $clog2(NUM_REGS + 1);

  logic [1:0]    rst_pipe;
  logic          rst_sync_n;
  logic          sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic          wr_en;
  logic [AW-1:0] wr_addr, ptr;
  logic [7:0]    wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_byte_engine #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .AW(AW)) u_eng (
    .clk(clk), .rst_n(rst_sync_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .rd_data(rd_data), .ptr(ptr), .sda_oe(sda_oe_o), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  i2c_reg_bank #(
    .NUM_REGS(NUM_REGS), .RO_COUNT(RO_COUNT), .BANK_ADDR(BANK_ADDR),
    .SEL_ADDR(SEL_ADDR), .SEL_BIT(SEL_BIT), .ID_BIT(ID_BIT), .AW(AW)
  ) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(ptr), .status_i(status_i), .cmon_i(cmon_i),
    .rd_data(rd_data), .ctrl_o(ctrl_o)
  );
endmodule

// File: rtl/i2c_regbank_checker.sv
// Property checker, bound into the top module.
module i2c_regbank_checker #(
  parameter int NUM_REGS  = 34,
  parameter int RO_COUNT  = 12,
  parameter int BANK_ADDR = 9,
  parameter int SEL_ADDR  = 14,
  parameter int SEL_BIT   = 0,
  parameter int ID_BIT    = 0,
  parameter int AW        = 6
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             stop_ev,
  input logic                             sda_oe,
  input logic                             wr_en,
  input logic [AW-1:0]                    wr_addr,
  input logic [7:0]                       wr_data,
  input logic [AW-1:0]                    ptr,
  input logic [7:0]                       rd_data,
  input logic [7:0]                       cmon,
  input logic [(NUM_REGS-RO_COUNT)*8-1:0] ctrl
);
  localparam int RW_COUNT = NUM_REGS - RO_COUNT;
  localparam int SEL_POS  = (SEL_ADDR - RO_COUNT) * 8 + SEL_BIT;

  logic [AW-1:0] last_addr;
  logic [7:0]    slot;
  logic          sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_addr <= '0;
    else        last_addr <= wr_addr;
  end

  always_comb begin
    slot = '0;
    for (int i = 0; i < RW_COUNT; i++)
      if (last_addr == AW'(RO_COUNT + i)) slot = ctrl[i*8 +: 8];
  end
  assign sel = ctrl[SEL_POS];

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= AW'(RO_COUNT) && wr_addr < AW'(NUM_REGS))
      |=> slot == $past(wr_data));
  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  p_ro_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr < AW'(RO_COUNT)) |=> $stable(ctrl));
  p_wr_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_addr < AW'(NUM_REGS));
  p_ptr_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= AW'(NUM_REGS));
  p_bank_alt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == AW'(BANK_ADDR) && sel) |-> rd_data == cmon);
  p_id_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == AW'(BANK_ADDR) && !sel) |-> rd_data[ID_BIT]);
  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);
endmodule

bind i2c_regbank_slave i2c_regbank_checker #(
  .NUM_REGS(NUM_REGS), .RO_COUNT(RO_COUNT), .BANK_ADDR(BANK_ADDR),
  .SEL_ADDR(SEL_ADDR), .SEL_BIT(SEL_BIT), .ID_BIT(ID_BIT), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .stop_ev(stop_ev), .sda_oe(sda_oe_o),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ptr(ptr),
  .rd_data(rd_data), .cmon(cmon_i), .ctrl(ctrl_o)
);

// File: tb/tb_i2c_regbank_slave.sv
`timescale 1ns/1ps
module tb_i2c_regbank_slave;
  localparam int Q = 8;

  logic         clk, rst_n;
  logic         scl_m, sda_m;
  logic         sda_oe_o, sda_bus;
  logic [95:0]  status_i;
  logic [7:0]   cmon_i, flag_byte;
  logic [175:0] ctrl_o;
  int           n_chk, n_bad;
  logic [7:0]   rbuf [4];
  logic         ackb;

  i2c_regbank_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe_o), .status_i(status_i), .cmon_i(cmon_i), .ctrl_o(ctrl_o)
  );

  assign sda_bus = sda_m & ~sda_oe_o;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] st_val(int i);
    return 8'(8'h30 + i * 13);
  endfunction

  always_comb begin
    for (int i = 0; i < 12; i++)
      status_i[i*8 +: 8] = (i == 9) ? flag_byte : st_val(i);
  end

  function automatic logic [7:0] ctrl_byte(int a);
    return ctrl_o[(a-12)*8 +: 8];
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq();
    end
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = sda_bus; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); b[i] = sda_bus; wq(); scl_m = 1'b0; wq();
    end
    sda_m = nack; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; sda_m = 1'b1; wq();
  endtask

  task automatic wr_regs(logic [7:0] sub, logic [7:0] d0, logic [7:0] d1,
                         logic [7:0] d2, logic [7:0] d3, int n, string tag);
    logic [7:0] d [4];
    logic a;
    d = '{d0, d1, d2, d3};
    i2c_start();
    send_byte(8'hDE, a); check({tag, " addr ack"}, a, 0);
    send_byte(sub, a);   check({tag, " sub ack"}, a, 0);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], a); check({tag, " data ack"}, a, 0);
    end
    i2c_stop();
  endtask

  task automatic set_ptr(logic [7:0] sub);
    logic a;
    i2c_start(); send_byte(8'hDE, a); send_byte(sub, a); i2c_stop();
  endtask

  task automatic rd_cur(int n);
    logic a;
    i2c_start(); send_byte(8'hDF, a);
    for (int i = 0; i < n; i++) recv_byte(i == n - 1, rbuf[i]);
    i2c_stop();
  endtask

  task automatic rd_regs(logic [7:0] sub, int n);
    set_ptr(sub); rd_cur(n);
  endtask

  // R11: reset state
  task automatic t_reset();
    check("R11 sda released after reset", sda_oe_o, 0);
    check("R11 control regs zero", (ctrl_o == '0), 1);
  endtask

  // R1: address matching
  task automatic t_address();
    logic a;
    i2c_start(); send_byte(8'hA0, a); i2c_stop();
    check("R1 foreign address not acked", a, 1);
    check("R1 sda released after foreign address", sda_oe_o, 0);
    i2c_start(); send_byte(8'hDE, a); i2c_stop();
    check("R1 own address acked", a, 0);
  endtask

  // R2, R5, R6: burst write and readback
  task automatic t_write_read();
    wr_regs(8'h0C, 8'hA1, 8'hB2, 8'hC2, 0, 3, "R2");
    check("R2 reg 0C", ctrl_byte(12), 8'hA1);
    check("R2 reg 0D", ctrl_byte(13), 8'hB2);
    check("R2 reg 0E", ctrl_byte(14), 8'hC2);
    rd_regs(8'h0C, 3);
    check("R5 read 0C", rbuf[0], 8'hA1);
    check("R5 read 0D", rbuf[1], 8'hB2);
    check("R6 read 0E", rbuf[2], 8'hC2);
    rd_regs(8'h03, 2);
    check("R6 read status 03", rbuf[0], st_val(3));
    check("R6 read status 04", rbuf[1], st_val(4));
  endtask

  // R3: read-only region
  task automatic t_readonly();
    wr_regs(8'h0A, 8'h55, 8'h66, 8'h77, 0, 3, "R3");
    rd_regs(8'h0A, 3);
    check("R3 status 0A untouched", rbuf[0], st_val(10));
    check("R3 status 0B untouched", rbuf[1], st_val(11));
    check("R3 pointer advanced into 0C", rbuf[2], 8'h77);
  endtask

  // R4: end of register space
  task automatic t_top_end();
    wr_regs(8'h20, 8'h11, 8'h22, 8'h33, 8'h44, 4, "R4");
    check("R4 reg 20", ctrl_byte(32), 8'h11);
    check("R4 reg 21", ctrl_byte(33), 8'h22);
    check("R4 no wrap into 0C", ctrl_byte(12), 8'h77);
    rd_regs(8'h1F, 4);
    check("R4 read 1F", rbuf[0], 8'h00);
    check("R4 read 20", rbuf[1], 8'h11);
    check("R4 read 21", rbuf[2], 8'h22);
    check("R4 read past end", rbuf[3], 8'h00);
  endtask

  // R7, R8: banked status address
  task automatic t_bank();
    wr_regs(8'h0E, 8'h00, 0, 0, 0, 1, "R7");
    flag_byte = 8'h5A; cmon_i = 8'h3C;
    rd_regs(8'h09, 1);
    check("R8 flag with id bit", rbuf[0], 8'h5B);
    flag_byte = 8'hA5;
    rd_regs(8'h09, 1);
    check("R8 flag id bit already set", rbuf[0], 8'hA5);
    wr_regs(8'h0E, 8'h01, 0, 0, 0, 1, "R7");
    rd_regs(8'h09, 1);
    check("R7 alternate bank", rbuf[0], 8'h3C);
    wr_regs(8'h0E, 8'h00, 0, 0, 0, 1, "R7");
    rd_regs(8'h09, 1);
    check("R7 back to flag bank", rbuf[0], 8'hA5);
  endtask

  // R9: master NACK releases the line
  task automatic t_nack();
    logic driven;
    logic [7:0] b;
    set_ptr(8'h0C);
    i2c_start(); send_byte(8'hDF, ackb);
    recv_byte(1'b1, b);
    check("R9 byte before nack", b, 8'h77);
    driven = 1'b0;
    sda_m = 1'b1;
    for (int i = 0; i < 9; i++) begin
      wq(); scl_m = 1'b1; wq(); driven |= sda_oe_o; wq(); scl_m = 1'b0; wq();
      driven |= sda_oe_o;
    end
    check("R9 sda stays released after nack", driven, 0);
    i2c_stop();
  endtask

  // R10: aborted bytes
  task automatic t_abort();
    logic a;
    wr_regs(8'h10, 8'h5A, 0, 0, 0, 1, "R10");
    i2c_start(); send_byte(8'hDE, a); send_byte(8'h10, a);
    send_bits(8'hFF, 4); i2c_stop();
    check("R10 stop mid-byte no write", ctrl_byte(16), 8'h5A);
    check("R10 sda released after stop", sda_oe_o, 0);
    i2c_start(); send_byte(8'hDE, a); send_byte(8'h10, a);
    send_bits(8'hC3, 3);
    i2c_start(); send_byte(8'hDE, a);
    check("R10 restart mid-byte reaccepts address", a, 0);
    i2c_stop();
    check("R10 restart mid-byte no write", ctrl_byte(16), 8'h5A);
  endtask

  // R5: pointer persists across transactions
  task automatic t_persist();
    wr_regs(8'h1D, 8'h9C, 8'h4E, 0, 0, 2, "R5");
    set_ptr(8'h1D);
    rd_cur(2);
    check("R5 read at stored pointer", rbuf[0], 8'h9C);
    check("R5 read next after stored pointer", rbuf[1], 8'h4E);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    summary();
  end

  initial begin
    n_chk = 0; n_bad = 0;
    scl_m = 1'b1; sda_m = 1'b1; flag_byte = 8'h00; cmon_i = 8'h00;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_address();
    t_write_read();
    t_readonly();
    t_top_end();
    t_bank();
    t_nack();
    t_abort();
    t_persist();
    summary();
  end
endmodule